// File: doc/BRIEF.md
# Coprocessor Countdown Interlock Controller

This block sits between a processor's coprocessor command path and a multi-cycle reconfigurable array. The processor presents one command at a time: select a configuration by a short name, start a run of a given number of cycles, move a word into or out of the array, or save or restore the array's internal state for a context swap. The block answers each cycle with a stall signal; a command is taken on the first clock edge at which it is valid and not stalled.

Configurations are held in a small cache of slots. Naming a resident configuration costs nothing; naming an absent one evicts the least recently used slot and holds every further command for a fixed load delay. A start command loads a countdown cycle counter that drops by one each cycle while the array runs. Each command carries an interlock flag: when set, the command waits until the counter reaches zero; when clear, it is taken while the array runs. Data moves, state save or restore and configuration changes always wait for zero, whatever their flag. The counter value is visible at all times on its own output, so reading it never stalls.

Top module: `cop_interlock_ctrl`

## Requirements
- R1: After reset, run_count is 0, cfg_ready and cfg_loading are 0, and stall is 0 while cmd_valid is 0.
- R2: A CFG command (cmd_op 1) whose name is not resident pulses cfg_miss in its accept cycle; cfg_loading is then high for exactly LOAD_CYCLES (default 32) cycles, during which every valid command is stalled.
- R3: A CFG command whose name is resident pulses cfg_hit in its accept cycle, starts no load, and sets cfg_slot to the slot holding that name.
- R4: The cache has NUM_SLOTS (default 4) slots with least-recently-used replacement; from reset, misses fill slots 0, 1, 2, 3 in that order, and both hits and misses make the slot the most recently used one.
- R5: A START command (cmd_op 2) accepted with a configuration resident makes run_count equal cmd_cycles in the next cycle; run_count then falls by one per cycle until it reaches 0 and holds there. A START with cmd_cycles 0 leaves run_count at 0.
- R6: A START accepted before any configuration has been named is ignored: run_count stays 0.
- R7: A command with cmd_lock 1 is stalled while run_count is non-zero and taken in the first cycle it is zero; a NOP (cmd_op 0, also 7) or START with cmd_lock 0 is taken at once even while the array runs, and such a START reloads the counter.
- R8: MVIN (3), MVOUT (4), SAVE (5) and RESTORE (6) are stalled while run_count is non-zero regardless of cmd_lock; when taken, xfer_stb is 1 in the accept cycle with xfer_kind 0, 1, 2 or 3 respectively.
- R9: A CFG command is stalled while run_count is non-zero regardless of cmd_lock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 3 | Command code |
| cmd_lock | input | 1 | Interlock flag: wait for counter zero |
| cmd_cfg | input | CFG_W | Configuration name for CFG |
| cmd_cycles | input | CNT_W | Run length for START |
| stall | output | 1 | Command held this cycle |
| cmd_accept | output | 1 | Command taken at this edge |
| cfg_hit | output | 1 | CFG found resident (accept cycle) |
| cfg_miss | output | 1 | CFG not resident, load begins (accept cycle) |
| cfg_slot | output | SLOT_W | Slot of the active configuration |
| cfg_loading | output | 1 | Configuration load in progress |
| cfg_ready | output | 1 | Active configuration resident and loaded |
| run_count | output | CNT_W | Current countdown value |
| run_busy | output | 1 | Counter non-zero |
| xfer_stb | output | 1 | Data move or state save/restore taken |
| xfer_kind | output | 2 | Kind of the transfer being taken |

## Verification
On every cycle the checker confirms that the countdown only falls by one unless reloaded, that interlocked commands, transfers and configuration changes are held while the counter is non-zero, that commands are held during a load, that a miss starts a load and that a transfer strobe never coincides with a stall. The bench's scenarios are needed for the cache's replacement order across a sequence of names, the exact length of the load delay, the exact number of stalled cycles before an interlocked command, the transfer kind codes, and the start ignored before any configuration exists.

// File: rtl/cop_pkg.sv
// Shared command encoding for the coprocessor interlock controller.
// Assumes a 3-bit command field; code 7 is reserved and behaves as a NOP.
package cop_pkg;
    typedef enum logic [2:0] {
        OP_NOP     = 3'd0,
        OP_CFG     = 3'd1,
        OP_START   = 3'd2,
        OP_MVIN    = 3'd3,
        OP_MVOUT   = 3'd4,
        OP_SAVE    = 3'd5,
        OP_RESTORE = 3'd6,
        OP_RSVD    = 3'd7
    } cop_op_e;
endpackage

// File: rtl/cop_down_counter.sv
// Loadable countdown counter: load wins, otherwise decrements while non-zero.
// Assumes load_val fits in W bits; holds at zero.
module cop_down_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] count,
    output logic         nz
);
    assign nz = (count != '0);

    // Count register: reset, reload or one-step decrement.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (load)
            count <= load_val;
        else if (nz)
            count <= count - 1'b1;
    end
endmodule

// File: rtl/cop_cfg_cache.sv
// Configuration name cache with least-recently-used replacement.
// Ages form a permutation of 0..NUM-1 (0 = most recent); NUM must be a
// power of two. Reset ages make slot 0 the first victim, then 1, 2, ...
module cop_cfg_cache #(
    parameter int NUM   = 4,
    parameter int TAG_W = 4,
    localparam int SW   = $clog2(NUM)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TAG_W-1:0] lookup_tag,
    input  logic             access,
    output logic             hit,
    output logic [SW-1:0]    sel
);
    logic [TAG_W-1:0] tag   [NUM];
    logic             vld   [NUM];
    logic [SW-1:0]    age   [NUM];
    logic [NUM-1:0]   match;
    logic [NUM-1:0]   oldest;
    logic [SW-1:0]    hit_idx;
    logic [SW-1:0]    lru_idx;

    for (genvar i = 0; i < NUM; i++) begin : g_cmp
        assign match[i]  = vld[i] && (tag[i] == lookup_tag);
        assign oldest[i] = (age[i] == SW'(NUM - 1));
    end

    // Encode the matching slot and the least recently used slot.
    always_comb begin
        hit_idx = '0;
        lru_idx = '0;
        for (int i = NUM - 1; i >= 0; i--) begin
            if (match[i])  hit_idx = SW'(i);
            if (oldest[i]) lru_idx = SW'(i);
        end
    end

    assign hit = |match;
    assign sel = hit ? hit_idx : lru_idx;

    // Slot state: fill the victim on a miss and refresh ages on each access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM; i++) begin
                tag[i] <= '0;
                vld[i] <= 1'b0;
                age[i] <= SW'(NUM - 1 - i);
            end
        end else if (access) begin
            for (int i = 0; i < NUM; i++) begin
                if (SW'(i) == sel) begin
                    age[i] <= '0;
                    if (!hit) begin
                        tag[i] <= lookup_tag;
                        vld[i] <= 1'b1;
                    end
                end else if (age[i] < age[sel]) begin
                    age[i] <= age[i] + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/cop_issue_ctrl.sv
// Command issue decode: decides stall and accept and classifies the command.
// Assumes one command in flight; purely combinational.
module cop_issue_ctrl
    import cop_pkg::*;
(
    input  logic       cmd_valid,
    input  logic [2:0] cmd_op,
    input  logic       cmd_lock,
    input  logic       loading,
    input  logic       run_nz,
    output logic       stall,
    output logic       accept,
    output logic       cfg_acc,
    output logic       start_acc,
    output logic       xfer_acc,
    output logic [1:0] xfer_kind
);
    cop_op_e op;
    logic    must_wait;

    assign op = cop_op_e'(cmd_op);

    // Classify which commands always wait for the counter to reach zero.
    always_comb begin
        must_wait = 1'b0;
        xfer_kind = 2'd0;
        unique case (op)
            OP_CFG:     must_wait = 1'b1;
            OP_MVIN:    begin must_wait = 1'b1; xfer_kind = 2'd0; end
            OP_MVOUT:   begin must_wait = 1'b1; xfer_kind = 2'd1; end
            OP_SAVE:    begin must_wait = 1'b1; xfer_kind = 2'd2; end
            OP_RESTORE: begin must_wait = 1'b1; xfer_kind = 2'd3; end
            default:    must_wait = 1'b0;
        endcase
    end

    assign stall     = cmd_valid && (loading || (run_nz && (cmd_lock || must_wait)));
    assign accept    = cmd_valid && !stall;
    assign cfg_acc   = accept && (op == OP_CFG);
    assign start_acc = accept && (op == OP_START);
    assign xfer_acc  = accept && (op inside {OP_MVIN, OP_MVOUT, OP_SAVE, OP_RESTORE});
endmodule

// File: rtl/cop_interlock_ctrl.sv
// Top of the coprocessor countdown interlock controller.
// Joins the issue decode, the configuration cache, the load-delay counter
// and the run countdown. Assumes NUM_SLOTS is a power of two.
module cop_interlock_ctrl #(
    parameter int CFG_W       = 4,
    parameter int CNT_W       = 8,
    parameter int NUM_SLOTS   = 4,
    parameter int LOAD_CYCLES = 32,
    localparam int SLOT_W     = $clog2(NUM_SLOTS),
    localparam int LD_W       = $clog2(LOAD_CYCLES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic              cmd_lock,
    input  logic [CFG_W-1:0]  cmd_cfg,
    input  logic [CNT_W-1:0]  cmd_cycles,
    output logic              stall,
    output logic              cmd_accept,
    output logic              cfg_hit,
    output logic              cfg_miss,
    output logic [SLOT_W-1:0] cfg_slot,
    output logic              cfg_loading,
    output logic              cfg_ready,
    output logic [CNT_W-1:0]  run_count,
    output logic              run_busy,
    output logic              xfer_stb,
    output logic [1:0]        xfer_kind
);
    logic              cfg_acc;
    logic              start_acc;
    logic              c_hit;
    logic [SLOT_W-1:0] c_sel;
    logic              have_cfg;
    logic [LD_W-1:0]   ld_count;

    cop_issue_ctrl u_issue (
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_lock  (cmd_lock),
        .loading   (cfg_loading),
        .run_nz    (run_busy),
        .stall     (stall),
        .accept    (cmd_accept),
        .cfg_acc   (cfg_acc),
        .start_acc (start_acc),
        .xfer_acc  (xfer_stb),
        .xfer_kind (xfer_kind)
    );

    cop_cfg_cache #(.NUM(NUM_SLOTS), .TAG_W(CFG_W)) u_cache (
        .clk        (clk),
        .rst_n      (rst_n),
        .lookup_tag (cmd_cfg),
        .access     (cfg_acc),
        .hit        (c_hit),
        .sel        (c_sel)
    );

    cop_down_counter #(.W(LD_W)) u_load_delay (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cfg_acc && !c_hit),
        .load_val (LD_W'(LOAD_CYCLES)),
        .count    (ld_count),
        .nz       (cfg_loading)
    );

    cop_down_counter #(.W(CNT_W)) u_run (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (start_acc && have_cfg),
        .load_val (cmd_cycles),
        .count    (run_count),
        .nz       (run_busy)
    );

    // Active configuration: slot of the last named configuration.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_slot <= '0;
            have_cfg <= 1'b0;
        end else if (cfg_acc) begin
            cfg_slot <= c_sel;
            have_cfg <= 1'b1;
        end
    end

    assign cfg_hit   = cfg_acc && c_hit;
    assign cfg_miss  = cfg_acc && !c_hit;
    assign cfg_ready = have_cfg && !cfg_loading;
endmodule

// File: rtl/cop_interlock_ctrl_chk.sv
// Cycle-level checker for the interlock controller, bound to the top.
// Observes ports only.
module cop_interlock_ctrl_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_valid,
    input logic [2:0]       cmd_op,
    input logic             cmd_lock,
    input logic             stall,
    input logic             cmd_accept,
    input logic             cfg_miss,
    input logic             cfg_loading,
    input logic [CNT_W-1:0] run_count,
    input logic             xfer_stb
);
    // R5
    run_decrement_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_count != '0 && !(cmd_accept && cmd_op == 3'd2))
        |=> (run_count == $past(run_count) - 1'b1));

    // R7
    lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_lock && run_count != '0) |-> stall);

    // R8
    xfer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op inside {3'd3, 3'd4, 3'd5, 3'd6} && run_count != '0) |-> stall);

    // R8
    xfer_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_stb |-> (!stall && run_count == '0));

    // R9
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 3'd1 && run_count != '0) |-> stall);

    // R2
    load_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_miss |=> cfg_loading);

    // R2
    load_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_loading && cmd_valid) |-> stall);
endmodule

bind cop_interlock_ctrl cop_interlock_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid   (cmd_valid),
    .cmd_op      (cmd_op),
    .cmd_lock    (cmd_lock),
    .stall       (stall),
    .cmd_accept  (cmd_accept),
    .cfg_miss    (cfg_miss),
    .cfg_loading (cfg_loading),
    .run_count   (run_count),
    .xfer_stb    (xfer_stb)
);

// File: tb/cop_interlock_ctrl_tb.sv
`timescale 1ns/100ps
module cop_interlock_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [2:0] cmd_op = 3'd0;
    logic       cmd_lock = 1'b0;
    logic [3:0] cmd_cfg = 4'd0;
    logic [7:0] cmd_cycles = 8'd0;
    logic       stall, cmd_accept, cfg_hit, cfg_miss, cfg_loading, cfg_ready;
    logic [1:0] cfg_slot;
    logic [7:0] run_count;
    logic       run_busy, xfer_stb;
    logic [1:0] xfer_kind;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    cop_interlock_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_lock(cmd_lock), .cmd_cfg(cmd_cfg), .cmd_cycles(cmd_cycles),
        .stall(stall), .cmd_accept(cmd_accept), .cfg_hit(cfg_hit),
        .cfg_miss(cfg_miss), .cfg_slot(cfg_slot), .cfg_loading(cfg_loading),
        .cfg_ready(cfg_ready), .run_count(run_count), .run_busy(run_busy),
        .xfer_stb(xfer_stb), .xfer_kind(xfer_kind)
    );

    typedef struct packed {
        logic [2:0] op;
        logic       lock;
        logic [3:0] cfg;
        logic [7:0] cyc;
        logic [7:0] waits;
        logic       hit;
        logic       miss;
        logic [1:0] slot;
    } vec_t;

    localparam int NV = 20;
    // op, lock, cfg, cycles, expected stalled cycles, hit, miss, slot after
    localparam vec_t VEC [NV] = '{
        '{3'd1, 1'b0, 4'd5,  8'd0,  8'd0,  1'b0, 1'b1, 2'd0},  // R2 R4 fill slot 0
        '{3'd1, 1'b0, 4'd5,  8'd0,  8'd32, 1'b1, 1'b0, 2'd0},  // R2 R3
        '{3'd1, 1'b0, 4'd9,  8'd0,  8'd0,  1'b0, 1'b1, 2'd1},  // R4
        '{3'd1, 1'b0, 4'd2,  8'd0,  8'd32, 1'b0, 1'b1, 2'd2},  // R4
        '{3'd1, 1'b0, 4'd7,  8'd0,  8'd32, 1'b0, 1'b1, 2'd3},  // R4
        '{3'd1, 1'b0, 4'd9,  8'd0,  8'd32, 1'b1, 1'b0, 2'd1},  // R3
        '{3'd1, 1'b0, 4'd5,  8'd0,  8'd0,  1'b1, 1'b0, 2'd0},  // R3
        '{3'd1, 1'b0, 4'd11, 8'd0,  8'd0,  1'b0, 1'b1, 2'd2},  // R4 evict LRU
        '{3'd1, 1'b0, 4'd2,  8'd0,  8'd32, 1'b0, 1'b1, 2'd3},  // R4 evicted name
        '{3'd2, 1'b0, 4'd0,  8'd10, 8'd32, 1'b0, 1'b0, 2'd3},  // R5
        '{3'd0, 1'b0, 4'd0,  8'd0,  8'd0,  1'b0, 1'b0, 2'd3},  // R7 free
        '{3'd0, 1'b1, 4'd0,  8'd0,  8'd9,  1'b0, 1'b0, 2'd3},  // R7 waits
        '{3'd2, 1'b1, 4'd0,  8'd5,  8'd0,  1'b0, 1'b0, 2'd3},  // R7
        '{3'd3, 1'b0, 4'd0,  8'd0,  8'd5,  1'b0, 1'b0, 2'd3},  // R8
        '{3'd2, 1'b0, 4'd0,  8'd4,  8'd0,  1'b0, 1'b0, 2'd3},  // R5
        '{3'd2, 1'b0, 4'd0,  8'd20, 8'd0,  1'b0, 1'b0, 2'd3},  // R7 reload
        '{3'd5, 1'b0, 4'd0,  8'd0,  8'd20, 1'b0, 1'b0, 2'd3},  // R8
        '{3'd1, 1'b0, 4'd5,  8'd0,  8'd0,  1'b1, 1'b0, 2'd0},  // R3
        '{3'd2, 1'b0, 4'd0,  8'd3,  8'd0,  1'b0, 1'b0, 2'd0},  // R5
        '{3'd1, 1'b0, 4'd7,  8'd0,  8'd3,  1'b0, 1'b1, 2'd1}   // R9 R4
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        cmd_valid = 1'b0;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Present a command, wait for acceptance, capture accept-cycle outputs.
    task automatic issue(input logic [2:0] op, input logic lock, input logic [3:0] cfg,
                         input logic [7:0] cyc, output int waits, output bit hit,
                         output bit miss, output bit xs, output logic [1:0] xk);
        @(negedge clk);
        cmd_op = op; cmd_lock = lock; cmd_cfg = cfg; cmd_cycles = cyc;
        cmd_valid = 1'b1;
        waits = 0;
        #1;
        while (stall && waits < 2000) begin
            @(negedge clk);
            #1;
            waits++;
        end
        hit = cfg_hit; miss = cfg_miss; xs = xfer_stb; xk = xfer_kind;
        @(posedge clk);
        #1;
        cmd_valid = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int w;
        bit h, m, xs;
        logic [1:0] xk;

        do_reset();
        // R1 reset state
        check(run_count == 8'd0, "R1 run_count", run_count, 0);
        check(!cfg_ready && !cfg_loading, "R1 cfg flags", {cfg_ready, cfg_loading}, 0);
        check(!stall, "R1 stall", stall, 0);

        // R6 start before any configuration
        issue(3'd2, 1'b0, 4'd0, 8'd10, w, h, m, xs, xk);
        check(run_count == 8'd0, "R6 start ignored", run_count, 0);

        do_reset();
        for (int i = 0; i < NV; i++) begin
            issue(VEC[i].op, VEC[i].lock, VEC[i].cfg, VEC[i].cyc, w, h, m, xs, xk);
            check(w == int'(VEC[i].waits), $sformatf("vec%0d stall cycles (R2 R7 R8 R9)", i), w, VEC[i].waits);
            check(h == VEC[i].hit, $sformatf("vec%0d hit (R3)", i), h, VEC[i].hit);
            check(m == VEC[i].miss, $sformatf("vec%0d miss (R2)", i), m, VEC[i].miss);
            check(cfg_slot == VEC[i].slot, $sformatf("vec%0d slot (R4)", i), cfg_slot, VEC[i].slot);
            if (VEC[i].op == 3'd2)
                check(run_count == VEC[i].cyc, $sformatf("vec%0d count (R5)", i), run_count, VEC[i].cyc);
        end

        // R2 exact load length and readiness
        do_reset();
        issue(3'd1, 1'b0, 4'd3, 8'd0, w, h, m, xs, xk);
        check(m, "R2 miss pulse", m, 1);
        check(!cfg_ready, "R2 not ready while loading", cfg_ready, 0);
        begin
            int n = 0;
            while (cfg_loading && n < 100) begin
                n++;
                @(posedge clk);
                #1;
            end
            check(n == 32, "R2 load length", n, 32);
        end
        check(cfg_ready, "R2 ready after load", cfg_ready, 1);

        // R5 countdown trace
        issue(3'd2, 1'b0, 4'd0, 8'd4, w, h, m, xs, xk);
        for (int k = 4; k >= 0; k--) begin
            check(run_count == 8'(k), "R5 countdown", run_count, k);
            @(posedge clk);
            #1;
        end
        check(run_count == 8'd0, "R5 holds at zero", run_count, 0);
        issue(3'd2, 1'b0, 4'd0, 8'd0, w, h, m, xs, xk);
        check(run_count == 8'd0 && !run_busy, "R5 zero start", run_count, 0);

        // R8 transfer kinds
        issue(3'd3, 1'b0, 4'd0, 8'd0, w, h, m, xs, xk);
        check(xs && xk == 2'd0, "R8 mvin kind", {xs, xk}, 4);
        issue(3'd4, 1'b1, 4'd0, 8'd0, w, h, m, xs, xk);
        check(xs && xk == 2'd1, "R8 mvout kind", {xs, xk}, 5);
        issue(3'd5, 1'b0, 4'd0, 8'd0, w, h, m, xs, xk);
        check(xs && xk == 2'd2, "R8 save kind", {xs, xk}, 6);
        issue(3'd6, 1'b0, 4'd0, 8'd0, w, h, m, xs, xk);
        check(xs && xk == 2'd3, "R8 restore kind", {xs, xk}, 7);
        issue(3'd0, 1'b0, 4'd0, 8'd0, w, h, m, xs, xk);
        check(!xs, "R8 nop no strobe", xs, 0);

        // R9 config change waits for run, flag clear
        issue(3'd2, 1'b0, 4'd0, 8'd6, w, h, m, xs, xk);
        issue(3'd1, 1'b0, 4'd3, 8'd0, w, h, m, xs, xk);
        check(w == 6, "R9 cfg waits", w, 6);
        check(h, "R9 cfg hit after wait", h, 1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule